// File: doc/BRIEF.md
# Indirectly Accessed Forwarding-Table Register Front End

This block puts a small register file in front of an on-chip forwarding table whose entries are 72 bits wide. Software never addresses a table entry directly. It stages an entry in three 32-bit word registers and then writes a table-control register. That write carries an entry index and a commit flag. With the flag clear, the indexed entry is copied into the word registers. With the flag set, the staged words are written into the indexed entry.

Beside the table path, the block offers a fixed identification register and a status register. The status register reports the table size, derived from the depth parameter. A global control register holds an enable bit, an ageout strobe and a clear command. The clear command wipes the whole table at one entry per clock and reads back as set until the wipe is done.

The host side is a simple single-cycle bus. A write takes effect on the clock edge where the write enable is high. Read data is a combinational function of the address and the registered state.

Top module: `fwd_tbl_regs`

## Requirements
- R1: After reset, the control, table-control and three word registers read 0, `tbl_enable` and `age_strobe` are 0, and every table entry holds all zeros.
- R2: Offset 0x00 reads the major version in bits 15:8 and the minor version in bits 7:0, with the upper bits 0 (0x0000_0105 by default).
- R3: Status offset 0x04 bits 4:0 give the table size in units of 1024 entries, with 0 meaning a 64-entry table; the other bits read 0. The default depth of 64 reads 0.
- R4: Writing offset 0x20 with bit 31 = 0 and an index below the depth loads that entry into the words: offset 0x3C gets entry bits 31:0, offset 0x38 gets bits 63:32, and offset 0x34 gets bits 71:64 in its bits 7:0.
- R5: Writing offset 0x20 with bit 31 = 1 and an index below the depth stores the three words into that entry, using the same bit placement as R4. A later load of that entry returns the stored value.
- R6: For an index in bits 30:0 at or beyond the depth, a commit leaves every entry unchanged, and a load sets all three words to 0.
- R7: Bit 31 of control offset 0x08 is a read/write enable that drives `tbl_enable`. It changes only when offset 0x08 is written.
- R8: Writing 1 to control bit 30 starts a clear. It erases one entry per cycle, so every entry becomes all zeros and therefore free (type bits 61:60 = 0). Bit 30 reads 1 for exactly DEPTH cycles after the write edge and then reads 0. The enable bit is kept.
- R9: Writing 1 to control bit 29 raises `age_strobe`, and bit 29 reads 1, for the single cycle after the write edge. Both are 0 afterwards.
- R10: The word register at offset 0x34 keeps only write bits 7:0, and its bits 31:8 read 0. Offset 0x20 reads back the last index in bits 30:0, and bit 31 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tbl_enable | output | 1 | Global enable bit |
| age_strobe | output | 1 | One-cycle ageout pulse |

## Verification
The hardest state to reach from the ports is the clear sweep: its effect is visible only through later indexed loads, and its busy window lasts a precise number of cycles. To cover it, the stimulus first commits distinct patterns into the first, a middle and the last entry. It then starts the clear and polls bit 30 on the last busy cycle and on the first idle cycle. Finally it reloads each seeded entry to confirm it is zero. The out-of-range commit is checked in a similar indirect way, through the in-range entry that shares its low index bits.

// File: rtl/fwd_tbl_pkg.sv
package fwd_tbl_pkg;
    localparam int ENTRY_W = 72;
    typedef logic [ENTRY_W-1:0] entry_t;

    localparam logic [7:0] OFS_ID     = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam logic [7:0] OFS_CTRL   = 8'h08;
    localparam logic [7:0] OFS_TCTRL  = 8'h20;
    localparam logic [7:0] OFS_WORD0  = 8'h34;
    localparam logic [7:0] OFS_WORD1  = 8'h38;
    localparam logic [7:0] OFS_WORD2  = 8'h3C;

    localparam int BIT_COMMIT = 31;
    localparam int BIT_EN     = 31;
    localparam int BIT_CLR    = 30;
    localparam int BIT_AGE    = 29;

    typedef struct packed {
        logic        enable;
        logic        age;
        logic [30:0] idx;
        logic [7:0]  w0;
        logic [31:0] w1;
        logic [31:0] w2;
    } regs_t;
endpackage

// File: rtl/fwd_tbl_store.sv
module fwd_tbl_store
    import fwd_tbl_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_data
);
    entry_t mem_q [DEPTH];
    entry_t mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/fwd_tbl_sweep.sv
module fwd_tbl_sweep #(
    parameter int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] wr_idx
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] cnt;
    } sweep_t;

    sweep_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = s_q.busy;
    assign wr_idx = s_q.cnt;
endmodule

// File: rtl/fwd_tbl_regs.sv
module fwd_tbl_regs
    import fwd_tbl_pkg::*;
#(
    parameter int          DEPTH     = 64,
    parameter logic [7:0]  VER_MAJOR = 8'h01,
    parameter logic [7:0]  VER_MINOR = 8'h05
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tbl_enable,
    output logic        age_strobe
);
    localparam int          IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [31:0] DEPTH_W   = 32'(DEPTH);
    localparam logic [4:0]  SIZE_CODE = (DEPTH == 64) ? 5'd0 : 5'(DEPTH / 1024);

    regs_t r_q, r_d;

    logic             wr_ctrl, wr_tctrl, idx_ok, host_commit;
    logic             sweep_busy;
    logic [IDX_W-1:0] sweep_idx;
    logic             st_we;
    logic [IDX_W-1:0] st_widx, st_ridx;
    entry_t           st_wdata, st_rdata;
    logic [71:0]      words_flat;

    assign wr_ctrl     = bus_we && (bus_addr == OFS_CTRL);
    assign wr_tctrl    = bus_we && (bus_addr == OFS_TCTRL);
    assign idx_ok      = {1'b0, bus_wdata[30:0]} < DEPTH_W;
    assign host_commit = wr_tctrl && bus_wdata[BIT_COMMIT] && idx_ok && !sweep_busy;
    assign words_flat  = {r_q.w0, r_q.w1, r_q.w2};

    assign st_we    = sweep_busy || host_commit;
    assign st_widx  = sweep_busy ? sweep_idx : bus_wdata[IDX_W-1:0];
    assign st_wdata = sweep_busy ? '0 : words_flat;
    assign st_ridx  = bus_wdata[IDX_W-1:0];

    fwd_tbl_sweep #(.DEPTH(DEPTH)) sweep_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_ctrl && bus_wdata[BIT_CLR]),
        .busy   (sweep_busy),
        .wr_idx (sweep_idx)
    );

    fwd_tbl_store #(.DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_we),
        .wr_idx  (st_widx),
        .wr_data (st_wdata),
        .rd_idx  (st_ridx),
        .rd_data (st_rdata)
    );

    always_comb begin
        r_d     = r_q;
        r_d.age = wr_ctrl && bus_wdata[BIT_AGE];
        if (wr_ctrl) begin
            r_d.enable = bus_wdata[BIT_EN];
        end
        if (wr_tctrl) begin
            r_d.idx = bus_wdata[30:0];
            if (!bus_wdata[BIT_COMMIT]) begin
                if (idx_ok) begin
                    {r_d.w0, r_d.w1, r_d.w2} = st_rdata;
                end else begin
                    {r_d.w0, r_d.w1, r_d.w2} = '0;
                end
            end
        end
        if (bus_we && bus_addr == OFS_WORD0) r_d.w0 = bus_wdata[7:0];
        if (bus_we && bus_addr == OFS_WORD1) r_d.w1 = bus_wdata;
        if (bus_we && bus_addr == OFS_WORD2) r_d.w2 = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_ID:     bus_rdata = {16'h0000, VER_MAJOR, VER_MINOR};
            OFS_STATUS: bus_rdata = {27'd0, SIZE_CODE};
            OFS_CTRL:   bus_rdata = {r_q.enable, sweep_busy, r_q.age, 29'd0};
            OFS_TCTRL:  bus_rdata = {1'b0, r_q.idx};
            OFS_WORD0:  bus_rdata = {24'd0, r_q.w0};
            OFS_WORD1:  bus_rdata = r_q.w1;
            OFS_WORD2:  bus_rdata = r_q.w2;
            default:    bus_rdata = '0;
        endcase
    end

    assign tbl_enable = r_q.enable;
    assign age_strobe = r_q.age;
endmodule

// File: rtl/fwd_tbl_regs_chk.sv
module fwd_tbl_regs_chk
    import fwd_tbl_pkg::*;
#(
    parameter int         DEPTH     = 64,
    parameter logic [7:0] VER_MAJOR = 8'h01,
    parameter logic [7:0] VER_MINOR = 8'h05
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        tbl_enable,
    input logic        age_strobe,
    input logic        sweep_busy,
    input logic [71:0] words_flat
);
    localparam logic [31:0] DEPTH_W = 32'(DEPTH);
    logic [31:0] busy_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run_q <= '0;
        else if (sweep_busy) busy_run_q <= busy_run_q + 1'b1;
        else busy_run_q <= '0;
    end

    assert_age_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        age_strobe |=> !age_strobe);

    assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_CTRL) |=> $stable(tbl_enable));

    assert_clear_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTRL && bus_wdata[BIT_CLR] && !sweep_busy) |=> sweep_busy);

    assert_clear_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_busy |-> (busy_run_q < DEPTH_W));

    assert_far_load_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_TCTRL && !bus_wdata[BIT_COMMIT]
         && {1'b0, bus_wdata[30:0]} >= DEPTH_W) |=> (words_flat == 72'd0));

    assert_id_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_ID) |-> (bus_rdata == {16'h0000, VER_MAJOR, VER_MINOR}));
endmodule

bind fwd_tbl_regs fwd_tbl_regs_chk #(
    .DEPTH(DEPTH), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tbl_enable (tbl_enable),
    .age_strobe (age_strobe),
    .sweep_busy (sweep_busy),
    .words_flat (words_flat)
);

// File: tb/fwd_tbl_regs_tb_top.sv
module fwd_tbl_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tbl_enable, age_strobe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_tbl_regs #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tbl_enable(tbl_enable), .age_strobe(age_strobe)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_words(input string req, input logic [71:0] exp);
        logic [31:0] v;
        rd(8'h34, v); chk(req, v, {24'd0, exp[71:64]});
        rd(8'h38, v); chk(req, v, exp[63:32]);
        rd(8'h3C, v); chk(req, v, exp[31:0]);
    endtask

    task automatic commit(input logic [31:0] idx, input logic [71:0] e);
        wr(8'h34, {24'hFFFFFF, e[71:64]});
        wr(8'h38, e[63:32]);
        wr(8'h3C, e[31:0]);
        wr(8'h20, 32'h8000_0000 | idx);
    endtask

    localparam logic [71:0] PAT_A = 72'hA5_1234_5678_9ABC_DEF0;
    localparam logic [71:0] PAT_B = 72'h3C_3000_0000_0000_0001;
    localparam logic [71:0] PAT_C = 72'hFF_FFFF_FFFF_FFFF_FFFF;
    localparam logic [71:0] PAT_D = 72'h01_0F0F_0F0F_F0F0_F0F0;

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h08, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h20, v); chk("R1 tctrl", v, 32'h0);
        chk_words("R1 words", 72'd0);
        chk("R1 enable", {31'd0, tbl_enable}, 32'd0);
        chk("R1 strobe", {31'd0, age_strobe}, 32'd0);
        wr(8'h20, 32'd5);
        chk_words("R1 entry5", 72'd0);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        rd(8'h00, v); chk("R2 id", v, 32'h0000_0105);
        rd(8'h04, v); chk("R3 status", v, 32'h0);
    endtask

    task automatic t_commit_load();
        logic [31:0] v;
        commit(32'd3, PAT_A);
        rd(8'h34, v); chk("R10 word0 width", v, {24'd0, PAT_A[71:64]});
        rd(8'h20, v); chk("R10 tctrl readback", v, 32'd3);
        commit(32'd63, PAT_B);
        commit(32'd0, PAT_C);
        wr(8'h20, 32'd3);  chk_words("R4 load 3", PAT_A);
        wr(8'h20, 32'd63); chk_words("R4 load 63", PAT_B);
        wr(8'h20, 32'd0);  chk_words("R5 load 0", PAT_C);
        wr(8'h20, 32'd1);  chk_words("R5 untouched 1", 72'd0);
    endtask

    task automatic t_far();
        commit(32'd64, PAT_D);
        wr(8'h20, 32'd0);  chk_words("R6 alias 0 kept", PAT_C);
        commit(32'h4000_0003, PAT_D);
        wr(8'h20, 32'd3);  chk_words("R6 alias 3 kept", PAT_A);
        wr(8'h20, 32'd64); chk_words("R6 far load zero", 72'd0);
        wr(8'h20, 32'h7FFF_FFFF); chk_words("R6 max load zero", 72'd0);
    endtask

    task automatic t_enable_age();
        logic [31:0] v;
        wr(8'h08, 32'h8000_0000);
        chk("R7 enable out", {31'd0, tbl_enable}, 32'd1);
        rd(8'h08, v); chk("R7 ctrl", v, 32'h8000_0000);
        wr(8'h3C, 32'h1);
        chk("R7 enable kept", {31'd0, tbl_enable}, 32'd1);
        wr(8'h08, 32'hA000_0000);
        chk("R9 strobe high", {31'd0, age_strobe}, 32'd1);
        rd(8'h08, v); chk("R9 ctrl age", v, 32'hA000_0000);
        @(negedge clk);
        chk("R9 strobe low", {31'd0, age_strobe}, 32'd0);
        rd(8'h08, v); chk("R9 ctrl after", v, 32'h8000_0000);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(8'h08, 32'hC000_0000);
        rd(8'h08, v); chk("R8 busy first", v, 32'hC000_0000);
        repeat (DEPTH - 1) @(negedge clk);
        rd(8'h08, v); chk("R8 busy last", v, 32'hC000_0000);
        @(negedge clk);
        rd(8'h08, v); chk("R8 done", v, 32'h8000_0000);
        wr(8'h20, 32'd0);  chk_words("R8 entry0", 72'd0);
        wr(8'h20, 32'd3);  chk_words("R8 entry3", 72'd0);
        wr(8'h20, 32'd63); chk_words("R8 entry63", 72'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_commit_load();
        t_far();
        t_enable_age();
        t_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule